// File: doc/BRIEF.md
# CAN Transmit Message Queue with Priority Slot

This block holds outgoing CAN message objects until a CAN protocol engine sends them. A message object has four 32-bit words: identifier, length code, first data word and second data word. Two stores sit side by side. One is an ordinary first-in first-out queue whose depth is a parameter (1 to 64 objects). The other is a single priority slot that holds one object. Software writes objects one word at a time over a plain write port. A target select picks the queue or the priority slot, and a word index places each word in the object.

A small scheduler offers one object at a time to the transmitter with a request/done handshake. When the priority slot is occupied at a decision point, its object goes first. The scheduler decides only between messages. Once a request is up, the offered object and its source stay fixed until the transmitter reports completion. That object is then removed and a transmit-OK pulse is issued. No new request starts unless the operating mode allows bus traffic. Objects queued in configuration or sleep mode wait there until an active mode returns.

Top module: `can_txq_top`

## Requirements
- R1: After reset the queue is empty, the priority slot is free, the request, both interrupt pulses and the overflow flag are 0, and `fifo_empty_o` is 1.
- R2: Words are written with `wr_word_i` = 0 (identifier), 1 (length code), 2 (data 1) and 3 (data 2). The object is committed to its target only on the write with index 3. Writes of indices 0 to 2 alone leave the queue and the slot unchanged.
- R3: Objects written to the queue (`wr_sel_i` = 0) are offered in the order they were committed. `tx_obj_o` packs identifier in bits 127:96, length code in 95:64, data 1 in 63:32 and data 2 in 31:0.
- R4: At a decision point, an occupied priority slot (`wr_sel_i` = 1 writes it) is offered before any queued object, and `tx_from_hp_o` is 1 for it.
- R5: While `tx_req_o` is high, `tx_obj_o` and `tx_from_hp_o` do not change, even if the priority slot is filled during that time.
- R6: Mode encoding on `mode_i`: 0 configuration, 1 normal, 2 sleep, 3 loopback, 4 snoop. A new request starts only in normal, loopback or snoop mode. In configuration and sleep modes, queued objects and the slot contents stay pending.
- R7: `fifo_full_o` is 1 exactly when the queue holds DEPTH objects. `hp_full_o` is 1 exactly while the priority slot holds an object.
- R8: A commit to a full queue or to an occupied priority slot is dropped and leaves the stored objects unchanged. It sets `ovf_o`, which stays 1 until reset.
- R9: The transmitter's done signal, seen while the request is high, removes the offered object. It drops `tx_req_o` and raises `irq_txok_o` for exactly one cycle, both in the cycle after the done.
- R10: `irq_fifo_empty_o` pulses for one cycle, in the first cycle the queue is empty after a removal took its last object.
- R11: `tx_done_i` while `tx_req_o` is low is ignored. No object is removed and no transmit-OK pulse is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i | input | 3 | Operating mode code |
| wr_en_i | input | 1 | Word write strobe |
| wr_sel_i | input | 1 | Target: 0 queue, 1 priority slot |
| wr_word_i | input | 2 | Word index within the object |
| wr_data_i | input | 32 | Word value |
| tx_req_o | output | 1 | Object offered to the transmitter |
| tx_obj_o | output | 128 | Offered object |
| tx_from_hp_o | output | 1 | Offered object came from the priority slot |
| tx_done_i | input | 1 | Transmitter reports successful send |
| fifo_full_o | output | 1 | Queue full |
| fifo_empty_o | output | 1 | Queue empty |
| hp_full_o | output | 1 | Priority slot occupied |
| irq_txok_o | output | 1 | Transmit-OK pulse |
| irq_fifo_empty_o | output | 1 | Queue-became-empty pulse |
| ovf_o | output | 1 | Sticky dropped-write flag |

## Verification
The assertions assume that the transmitter raises `tx_done_i` only while a request is up and holds it for a single cycle. They also assume that `mode_i` and the write inputs change only between clock edges. The bench drives every input on the falling edge. It pulses the done signal for one cycle after it has seen the request high. Only one test raises done without a request, and it does so deliberately to check that the pulse is ignored. The assertions still hold in that case, because they are conditioned on the request.

// File: rtl/can_txq_pkg.sv
package can_txq_pkg;

  typedef struct packed {
    logic [31:0] ident;
    logic [31:0] len_code;
    logic [31:0] data_a;
    logic [31:0] data_b;
  } txq_obj_t;

  localparam int unsigned OBJ_W   = $bits(txq_obj_t);
  localparam int unsigned N_TGT   = 2;
  localparam logic [1:0]  LAST_WD = 2'd3;

  typedef enum logic [2:0] {
    MD_CONFIG = 3'd0,
    MD_NORMAL = 3'd1,
    MD_SLEEP  = 3'd2,
    MD_LOOP   = 3'd3,
    MD_SNOOP  = 3'd4
  } txq_mode_e;

  // True for modes in which a new transmission may begin.
  function automatic logic mode_serves(input logic [2:0] m);
    return (m == MD_NORMAL) || (m == MD_LOOP) || (m == MD_SNOOP);
  endfunction

  // Build an object from three staged words and the final word.
  function automatic txq_obj_t pack_obj(input logic [31:0] w0, input logic [31:0] w1,
                                        input logic [31:0] w2, input logic [31:0] w3);
    txq_obj_t o;
    o.ident    = w0;
    o.len_code = w1;
    o.data_a   = w2;
    o.data_b   = w3;
    return o;
  endfunction

endpackage

// File: rtl/can_txq_stage.sv
module can_txq_stage
  import can_txq_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [1:0]  wr_word,
  input  logic [31:0] wr_data,
  output logic        commit_o,
  output txq_obj_t    obj_o
);

  logic [31:0] w0_q, w1_q, w2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      w0_q <= '0;
      w1_q <= '0;
      w2_q <= '0;
    end else if (wr_en) begin
      case (wr_word)
        2'd0:    w0_q <= wr_data;
        2'd1:    w1_q <= wr_data;
        2'd2:    w2_q <= wr_data;
        default: ;
      endcase
    end
  end

  assign commit_o = wr_en && (wr_word == LAST_WD);
  assign obj_o    = pack_obj(w0_q, w1_q, w2_q, wr_data);

endmodule

// File: rtl/can_txq_fifo.sv
module can_txq_fifo
  import can_txq_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          push,
  input  txq_obj_t                      push_obj,
  input  logic                          pop,
  output txq_obj_t                      head_obj,
  output logic [$clog2(DEPTH+1)-1:0]    count,
  output logic                          full,
  output logic                          empty
);

  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNT_W = $clog2(DEPTH+1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + 1'b1;
  endfunction

  txq_obj_t          mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic [CNT_W-1:0]  cnt_q;
  logic              do_push, do_pop;

  assign full    = (cnt_q == CNT_W'(DEPTH));
  assign empty   = (cnt_q == '0);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_obj;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      cnt_q  <= '0;
    end else begin
      if (do_push) wr_ptr <= ptr_next(wr_ptr);
      if (do_pop)  rd_ptr <= ptr_next(rd_ptr);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: ;
      endcase
    end
  end

  assign head_obj = mem[rd_ptr];
  assign count    = cnt_q;

endmodule

// File: rtl/can_txq_sched.sv
module can_txq_sched
  import can_txq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] mode,
  input  logic       hp_valid,
  input  logic       fifo_empty,
  input  logic       tx_done,
  output logic       busy_o,
  output logic       src_hp_o,
  output logic       start_o,
  output logic       pop_hp_o,
  output logic       pop_fifo_o,
  output logic       txok_o
);

  logic busy_q, src_hp_q, txok_q, finish;

  assign start_o    = !busy_q && mode_serves(mode) && (hp_valid || !fifo_empty);
  assign finish     = busy_q && tx_done;
  assign pop_hp_o   = finish && src_hp_q;
  assign pop_fifo_o = finish && !src_hp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      src_hp_q <= 1'b0;
      txok_q   <= 1'b0;
    end else begin
      txok_q <= finish;
      if (start_o) begin
        busy_q   <= 1'b1;
        src_hp_q <= hp_valid;
      end else if (finish) begin
        busy_q <= 1'b0;
      end
    end
  end

  assign busy_o   = busy_q;
  assign src_hp_o = src_hp_q;
  assign txok_o   = txok_q;

endmodule

// File: rtl/can_txq_top.sv
module can_txq_top
  import can_txq_pkg::*;
#(
  parameter int unsigned DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   mode_i,
  input  logic         wr_en_i,
  input  logic         wr_sel_i,
  input  logic [1:0]   wr_word_i,
  input  logic [31:0]  wr_data_i,
  output logic         tx_req_o,
  output logic [127:0] tx_obj_o,
  output logic         tx_from_hp_o,
  input  logic         tx_done_i,
  output logic         fifo_full_o,
  output logic         fifo_empty_o,
  output logic         hp_full_o,
  output logic         irq_txok_o,
  output logic         irq_fifo_empty_o,
  output logic         ovf_o
);

  localparam int unsigned CNT_W = $clog2(DEPTH+1);

  logic     commit [N_TGT];
  txq_obj_t stg_obj [N_TGT];

  for (genvar g = 0; g < N_TGT; g++) begin : g_stage
    can_txq_stage u_stage (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en_i && (wr_sel_i == 1'(g))),
      .wr_word  (wr_word_i),
      .wr_data  (wr_data_i),
      .commit_o (commit[g]),
      .obj_o    (stg_obj[g])
    );
  end

  // Named internal events
  logic     start_evt, pop_hp, pop_fifo, push_fifo, drop_evt, drain_evt;
  logic     busy, src_hp, txok;
  logic     f_full, f_empty;
  logic [CNT_W-1:0] f_count;
  txq_obj_t f_head;
  txq_obj_t hp_obj_q;
  logic     hp_valid_q, ovf_q, drain_q;

  assign push_fifo = commit[0] && !f_full;
  assign drop_evt  = (commit[0] && f_full) || (commit[1] && hp_valid_q);
  assign drain_evt = pop_fifo && !push_fifo && (f_count == CNT_W'(1));

  can_txq_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk      (clk),
    .rst_n    (rst_n),
    .push     (push_fifo),
    .push_obj (stg_obj[0]),
    .pop      (pop_fifo),
    .head_obj (f_head),
    .count    (f_count),
    .full     (f_full),
    .empty    (f_empty)
  );

  can_txq_sched u_sched (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode_i),
    .hp_valid   (hp_valid_q),
    .fifo_empty (f_empty),
    .tx_done    (tx_done_i),
    .busy_o     (busy),
    .src_hp_o   (src_hp),
    .start_o    (start_evt),
    .pop_hp_o   (pop_hp),
    .pop_fifo_o (pop_fifo),
    .txok_o     (txok)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hp_obj_q   <= '0;
      hp_valid_q <= 1'b0;
      ovf_q      <= 1'b0;
      drain_q    <= 1'b0;
    end else begin
      drain_q <= drain_evt;
      if (drop_evt) ovf_q <= 1'b1;
      if (pop_hp) begin
        hp_valid_q <= 1'b0;
      end else if (commit[1] && !hp_valid_q) begin
        hp_valid_q <= 1'b1;
        hp_obj_q   <= stg_obj[1];
      end
    end
  end

  assign tx_req_o         = busy;
  assign tx_from_hp_o     = src_hp;
  assign tx_obj_o         = src_hp ? hp_obj_q : f_head;
  assign fifo_full_o      = f_full;
  assign fifo_empty_o     = f_empty;
  assign hp_full_o        = hp_valid_q;
  assign irq_txok_o       = txok;
  assign irq_fifo_empty_o = drain_q;
  assign ovf_o            = ovf_q;

endmodule

// File: rtl/can_txq_chk.sv
module can_txq_chk (
  input logic         clk,
  input logic         rst_n,
  input logic [2:0]   mode_i,
  input logic         tx_req_o,
  input logic         tx_done_i,
  input logic         tx_from_hp_o,
  input logic [127:0] tx_obj_o,
  input logic         hp_full_o,
  input logic         fifo_full_o,
  input logic         fifo_empty_o,
  input logic         irq_txok_o,
  input logic         irq_fifo_empty_o,
  input logic         ovf_o,
  input logic         start_evt,
  input logic         drop_evt
);

  logic active_mode;
  assign active_mode = (mode_i == 3'd1) || (mode_i == 3'd3) || (mode_i == 3'd4);

  assert_start_in_active_R6: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |-> active_mode);

  assert_rise_needs_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_req_o) |-> $past(active_mode));

  assert_hp_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_req_o) && $past(hp_full_o) |-> tx_from_hp_o);

  assert_offer_stable_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req_o && !tx_done_i |=> tx_req_o && $stable(tx_obj_o) && $stable(tx_from_hp_o));

  assert_done_completes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_req_o && tx_done_i |=> !tx_req_o && irq_txok_o);

  assert_txok_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq_txok_o |=> !irq_txok_o);

  assert_idle_done_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_req_o |=> !irq_txok_o);

  assert_full_not_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_full_o |-> !fifo_empty_o);

  assert_drop_flags_R8: assert property (@(posedge clk) disable iff (!rst_n)
    drop_evt |=> ovf_o);

  assert_ovf_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ovf_o) |-> 1'b0);

  assert_drain_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_fifo_empty_o |-> fifo_empty_o);

  assert_drain_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_fifo_empty_o |=> !irq_fifo_empty_o);

endmodule

bind can_txq_top can_txq_chk u_chk (
  .clk              (clk),
  .rst_n            (rst_n),
  .mode_i           (mode_i),
  .tx_req_o         (tx_req_o),
  .tx_done_i        (tx_done_i),
  .tx_from_hp_o     (tx_from_hp_o),
  .tx_obj_o         (tx_obj_o),
  .hp_full_o        (hp_full_o),
  .fifo_full_o      (fifo_full_o),
  .fifo_empty_o     (fifo_empty_o),
  .irq_txok_o       (irq_txok_o),
  .irq_fifo_empty_o (irq_fifo_empty_o),
  .ovf_o            (ovf_o),
  .start_evt        (start_evt),
  .drop_evt         (drop_evt)
);

// File: tb/sim_can_txq_top.sv
module sim_can_txq_top;

  localparam int unsigned DEPTH = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [2:0]   mode_i = 3'd0;
  logic         wr_en_i = 1'b0;
  logic         wr_sel_i = 1'b0;
  logic [1:0]   wr_word_i = 2'd0;
  logic [31:0]  wr_data_i = '0;
  logic         tx_req_o;
  logic [127:0] tx_obj_o;
  logic         tx_from_hp_o;
  logic         tx_done_i = 1'b0;
  logic         fifo_full_o, fifo_empty_o, hp_full_o;
  logic         irq_txok_o, irq_fifo_empty_o, ovf_o;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  can_txq_top #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i),
    .wr_en_i(wr_en_i), .wr_sel_i(wr_sel_i), .wr_word_i(wr_word_i), .wr_data_i(wr_data_i),
    .tx_req_o(tx_req_o), .tx_obj_o(tx_obj_o), .tx_from_hp_o(tx_from_hp_o), .tx_done_i(tx_done_i),
    .fifo_full_o(fifo_full_o), .fifo_empty_o(fifo_empty_o), .hp_full_o(hp_full_o),
    .irq_txok_o(irq_txok_o), .irq_fifo_empty_o(irq_fifo_empty_o), .ovf_o(ovf_o)
  );

  function automatic logic [127:0] mk(input int k);
    return {32'h1000_0000 + 32'(k), 32'(k % 9), 32'hA0A0_0000 + 32'(k), 32'hB0B0_0000 + 32'(k)};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic write_obj(input bit sel, input logic [127:0] obj);
    for (int w = 0; w < 4; w++) begin
      @(negedge clk);
      wr_en_i   = 1'b1;
      wr_sel_i  = sel;
      wr_word_i = 2'(w);
      wr_data_i = obj[127 - 32*w -: 32];
    end
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic serve(input logic [127:0] exp_obj, input bit exp_hp, input bit exp_drain,
                       input string tag);
    int n = 0;
    while (!tx_req_o && n < 20) begin
      @(negedge clk);
      n++;
    end
    chk(tx_req_o == 1'b1, tag, "request seen", 128'(tx_req_o), 128'd1);
    chk(tx_obj_o == exp_obj, "R3", "offered object", tx_obj_o, exp_obj);
    chk(tx_from_hp_o == exp_hp, "R4", "source flag", 128'(tx_from_hp_o), 128'(exp_hp));
    tx_done_i = 1'b1;
    @(negedge clk);
    tx_done_i = 1'b0;
    chk(irq_txok_o == 1'b1, "R9", "txok pulse", 128'(irq_txok_o), 128'd1);
    chk(tx_req_o == 1'b0, "R9", "request dropped", 128'(tx_req_o), 128'd0);
    chk(irq_fifo_empty_o == exp_drain, "R10", "drain pulse", 128'(irq_fifo_empty_o), 128'(exp_drain));
    @(negedge clk);
    chk(irq_txok_o == 1'b0, "R9", "txok one cycle", 128'(irq_txok_o), 128'd0);
    chk(irq_fifo_empty_o == 1'b0, "R10", "drain one cycle", 128'(irq_fifo_empty_o), 128'd0);
  endtask

  task automatic t_reset();
    chk(fifo_empty_o && !fifo_full_o && !hp_full_o, "R1", "status after reset",
        {125'd0, fifo_empty_o, fifo_full_o, hp_full_o}, 128'd4);
    chk(!tx_req_o && !irq_txok_o && !irq_fifo_empty_o && !ovf_o, "R1", "outputs after reset",
        {124'd0, tx_req_o, irq_txok_o, irq_fifo_empty_o, ovf_o}, 128'd0);
  endtask

  task automatic t_partial();
    logic [127:0] o = mk(1);
    mode_i = 3'd0;
    for (int w = 0; w < 3; w++) begin
      @(negedge clk);
      wr_en_i = 1'b1; wr_sel_i = 1'b0; wr_word_i = 2'(w); wr_data_i = o[127 - 32*w -: 32];
    end
    @(negedge clk);
    wr_en_i = 1'b0;
    chk(fifo_empty_o == 1'b1, "R2", "no commit before last word", 128'(fifo_empty_o), 128'd1);
    @(negedge clk);
    wr_en_i = 1'b1; wr_word_i = 2'd3; wr_data_i = o[31:0];
    @(negedge clk);
    wr_en_i = 1'b0;
    chk(fifo_empty_o == 1'b0, "R2", "commit on last word", 128'(fifo_empty_o), 128'd0);
    mode_i = 3'd1;
    serve(o, 1'b0, 1'b1, "R2");
  endtask

  task automatic t_order();
    mode_i = 3'd0;
    for (int k = 10; k < 13; k++) write_obj(1'b0, mk(k));
    mode_i = 3'd1;
    for (int k = 10; k < 13; k++) serve(mk(k), 1'b0, k == 12, "R3");
  endtask

  task automatic t_preempt();
    mode_i = 3'd0;
    write_obj(1'b0, mk(20));
    write_obj(1'b0, mk(21));
    write_obj(1'b1, mk(22));
    mode_i = 3'd1;
    serve(mk(22), 1'b1, 1'b0, "R4");
    serve(mk(20), 1'b0, 1'b0, "R4");
    serve(mk(21), 1'b0, 1'b1, "R4");
  endtask

  task automatic t_no_reeval();
    mode_i = 3'd0;
    write_obj(1'b0, mk(30));
    mode_i = 3'd1;
    repeat (3) @(negedge clk);
    chk(tx_req_o && !tx_from_hp_o, "R5", "fifo object in flight",
        {126'd0, tx_req_o, tx_from_hp_o}, 128'd2);
    write_obj(1'b1, mk(31));
    chk(hp_full_o == 1'b1, "R7", "slot filled", 128'(hp_full_o), 128'd1);
    chk(tx_obj_o == mk(30) && !tx_from_hp_o, "R5", "offer unchanged", tx_obj_o, mk(30));
    serve(mk(30), 1'b0, 1'b1, "R5");
    serve(mk(31), 1'b1, 1'b0, "R5");
  endtask

  task automatic t_modes();
    mode_i = 3'd0;
    write_obj(1'b0, mk(40));
    mode_i = 3'd2;
    write_obj(1'b1, mk(41));
    repeat (6) @(negedge clk);
    chk(tx_req_o == 1'b0, "R6", "no service in sleep", 128'(tx_req_o), 128'd0);
    chk(!fifo_empty_o && hp_full_o, "R6", "objects kept in sleep",
        {126'd0, fifo_empty_o, hp_full_o}, 128'd1);
    mode_i = 3'd0;
    repeat (4) @(negedge clk);
    chk(tx_req_o == 1'b0, "R6", "no service in config", 128'(tx_req_o), 128'd0);
    mode_i = 3'd3;
    serve(mk(41), 1'b1, 1'b0, "R6");
    mode_i = 3'd4;
    serve(mk(40), 1'b0, 1'b1, "R6");
  endtask

  task automatic t_idle_done();
    mode_i = 3'd0;
    write_obj(1'b0, mk(50));
    @(negedge clk);
    tx_done_i = 1'b1;
    @(negedge clk);
    tx_done_i = 1'b0;
    chk(irq_txok_o == 1'b0, "R11", "no txok without request", 128'(irq_txok_o), 128'd0);
    chk(fifo_empty_o == 1'b0, "R11", "object not removed", 128'(fifo_empty_o), 128'd0);
    mode_i = 3'd1;
    serve(mk(50), 1'b0, 1'b1, "R11");
  endtask

  task automatic t_full();
    chk(ovf_o == 1'b0, "R8", "no overflow yet", 128'(ovf_o), 128'd0);
    mode_i = 3'd0;
    for (int k = 60; k < 60 + int'(DEPTH); k++) write_obj(1'b0, mk(k));
    chk(fifo_full_o == 1'b1, "R7", "queue full at depth", 128'(fifo_full_o), 128'd1);
    write_obj(1'b0, mk(99));
    chk(ovf_o == 1'b1, "R8", "overflow on full queue", 128'(ovf_o), 128'd1);
    write_obj(1'b1, mk(70));
    write_obj(1'b1, mk(71));
    chk(hp_full_o == 1'b1, "R7", "slot full", 128'(hp_full_o), 128'd1);
    mode_i = 3'd1;
    serve(mk(70), 1'b1, 1'b0, "R8");
    chk(hp_full_o == 1'b0 && fifo_full_o == 1'b1, "R7", "slot freed, queue still full",
        {126'd0, hp_full_o, fifo_full_o}, 128'd1);
    for (int k = 60; k < 60 + int'(DEPTH); k++)
      serve(mk(k), 1'b0, k == 60 + int'(DEPTH) - 1, "R8");
    repeat (3) @(negedge clk);
    chk(tx_req_o == 1'b0 && fifo_empty_o && !hp_full_o, "R8", "dropped objects absent",
        {125'd0, tx_req_o, fifo_empty_o, hp_full_o}, 128'd2);
    chk(ovf_o == 1'b1, "R8", "overflow sticky", 128'(ovf_o), 128'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_partial();
    t_order();
    t_preempt();
    t_no_reeval();
    t_modes();
    t_idle_done();
    t_full();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule